// File: doc/BRIEF.md
# GPIO Port with Function Priority

An eight-bit general-purpose I/O port reached through a small single-cycle register bus. Software sees three byte registers: a port latch, a read-only view of the pins, and a direction mask. The block drives each pad's output value and output enable. It takes the raw pad input levels and passes them through a two-flop synchronizer before anything reads them.

Two pins can be taken over by alternate functions. The shared pin can be claimed by a serial transmit channel ("tx B") and by a chip-select output. The serial channel beats the chip select, and the chip select beats GPIO. The solo pin can be claimed only by a second serial transmit channel ("tx A"). While an alternate function owns a pin, the pad is driven and takes its value from that function. The latch and direction bits of that pin keep their contents but have no effect on it.

The view of the pins lets software compare the level it drives with the level actually on each pin. A mismatch on a driven pin shows an overload or a short.

Top module: `gpio_port_prio`

## Requirements
- R1: A read of the data register (address 0) returns, for each bit whose direction bit is 1, the stored latch bit.
- R2: A read of the data register returns, for each bit whose direction bit is 0, the synchronized pin level.
- R3: A read of the input register (address 1) returns the synchronized pin level on all 8 bits, whatever the direction bits are.
- R4: A write to the input register (address 1) changes neither the latch nor the direction register.
- R5: After reset the direction register and the latch read as 0, every pad_oe bit is 0, and bus_rdata is 0.
- R6: On the shared pin (bit 0), when tx B is enabled, pad_oe[0] is 1 and pad_out[0] equals tx B's value, whatever the chip-select inputs are.
- R7: On the shared pin, when tx B is disabled and the chip select is enabled, pad_oe[0] is 1 and pad_out[0] equals the chip-select value.
- R8: On the solo pin (bit 1), when tx A is enabled, pad_oe[1] is 1 and pad_out[1] equals tx A's value.
- R9: Every pin that no alternate function owns has pad_oe equal to its direction bit and pad_out equal to its latch bit.
- R10: A data-register write updates every latch bit, whatever the direction bits are and whether an alternate function owns the pin. The stored value drives the pin once the pin returns to GPIO with its direction bit at 1.
- R11: A change on pad_in is seen by a read whose strobe comes two or more cycles after the change, and is not seen by a read whose strobe comes earlier.
- R12: The direction register is at address 2. Address 3 reads as 0, and writes to it change nothing.
- R13: Read data appears on bus_rdata in the cycle after the read strobe (bus_sel=1, bus_wr=0) and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 input, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| txa_en | input | 1 | tx A owns the solo pin (bit 1) |
| txa_val | input | 1 | tx A output level |
| txb_en | input | 1 | tx B owns the shared pin (bit 0), highest priority |
| txb_val | input | 1 | tx B output level |
| cs_en | input | 1 | Chip select owns the shared pin when tx B is disabled |
| cs_val | input | 1 | Chip-select output level |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest situation to reach from the ports is a latch write made while an alternate function owns the pin, followed by a read after that function lets go. The bench sweeps all 64 combinations of the six override inputs with a fresh latch value written under each combination. It then releases the overrides and checks that the last written value drives the pins. The data-register read mux is swept over all 256 direction masks against shifting pin patterns. The synchronizer delay is measured with back-to-back reads that start in the same cycle as a pin change.

// File: rtl/gpio_prio_pkg.sv
// Shared constants for the priority GPIO port.
// Assumes a two-bit register address; the input register is placed
// directly below the direction register.
package gpio_prio_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] A_INPUT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIR   = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for the pad inputs.
// Assumes pad_in is asynchronous. It carries no reset, because the pin view has
// no reset value of its own.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Purpose: shift the raw pin levels through two flops.
    always_ff @(posedge clk) begin
        stage1 <= d;
        q      <= stage1;
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file for the port: latch, direction and registered read mux.
// Assumes single-cycle accesses. Read data is captured at the strobe edge.
module gpio_regs
    import gpio_prio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q
);
    logic          wr_stb;
    logic          rd_stb;
    logic [W-1:0]  rd_mux;

    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;

    // Purpose: port latch, written in every bit whatever the direction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_stb && bus_addr == A_DATA)
            latch_q <= bus_wdata;
    end

    // Purpose: direction mask, 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_stb && bus_addr == A_DIR)
            dir_q <= bus_wdata;
    end

    // Purpose: select the read value by address.
    always_comb begin
        case (bus_addr)
            A_DATA:  rd_mux = (latch_q & dir_q) | (pin_sync & ~dir_q);
            A_INPUT: rd_mux = pin_sync;
            A_DIR:   rd_mux = dir_q;
            default: rd_mux = '0;
        endcase
    end

    // Purpose: register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_stb)
            bus_rdata <= rd_mux;
    end

    // R4: a write to the input register leaves the state alone
    p_input_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bus_addr == A_INPUT) |=> ($stable(latch_q) && $stable(dir_q)));

    // R12: a write to the unused address leaves the state alone
    p_unused_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bus_addr == 2'd3) |=> ($stable(latch_q) && $stable(dir_q)));

    // R13: read data holds when there is no read strobe
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_pad_mux.sv
// Per-pin output selection with fixed priority.
// Assumes SHARED_PIN != SOLO_PIN. The shared pin gives tx B priority over
// the chip select and the chip select priority over GPIO. The solo pin
// gives tx A priority over GPIO.
module gpio_pad_mux #(
    parameter int W          = 8,
    parameter int SHARED_PIN = 0,
    parameter int SOLO_PIN   = 1
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic         txa_en,
    input  logic         txa_val,
    input  logic         txb_en,
    input  logic         txb_val,
    input  logic         cs_en,
    input  logic         cs_val,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == SHARED_PIN) begin : g_shared
            // Purpose: tx B, then chip select, then GPIO.
            always_comb begin
                if (txb_en) begin
                    pad_out[i] = txb_val;
                    pad_oe[i]  = 1'b1;
                end else if (cs_en) begin
                    pad_out[i] = cs_val;
                    pad_oe[i]  = 1'b1;
                end else begin
                    pad_out[i] = latch_q[i];
                    pad_oe[i]  = dir_q[i];
                end
            end
        end else if (i == SOLO_PIN) begin : g_solo
            // Purpose: tx A, then GPIO.
            always_comb begin
                if (txa_en) begin
                    pad_out[i] = txa_val;
                    pad_oe[i]  = 1'b1;
                end else begin
                    pad_out[i] = latch_q[i];
                    pad_oe[i]  = dir_q[i];
                end
            end
        end else begin : g_plain
            assign pad_out[i] = latch_q[i];
            assign pad_oe[i]  = dir_q[i];
        end
    end
endmodule

// File: rtl/gpio_port_prio.sv
// Top level of the eight-bit priority GPIO port.
// Assumes pad_in is asynchronous to clk and that the bus issues one access
// per strobe cycle. Reset is synchronous and active low.
module gpio_port_prio
    import gpio_prio_pkg::*;
#(
    parameter int W          = 8,
    parameter int SHARED_PIN = 0,
    parameter int SOLO_PIN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              txa_en,
    input  logic              txa_val,
    input  logic              txb_en,
    input  logic              txb_val,
    input  logic              cs_en,
    input  logic              cs_val,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q)
    );

    gpio_pad_mux #(.W(W), .SHARED_PIN(SHARED_PIN), .SOLO_PIN(SOLO_PIN)) u_mux (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .txa_en  (txa_en),
        .txa_val (txa_val),
        .txb_en  (txb_en),
        .txb_val (txb_val),
        .cs_en   (cs_en),
        .cs_val  (cs_val),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // R6: tx B owns the shared pin
    p_txb_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txb_en |-> (pad_oe[SHARED_PIN] && pad_out[SHARED_PIN] == txb_val));

    // R7: chip select owns the shared pin when tx B is off
    p_cs_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!txb_en && cs_en) |-> (pad_oe[SHARED_PIN] && pad_out[SHARED_PIN] == cs_val));

    // R8: tx A owns the solo pin
    p_txa_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txa_en |-> (pad_oe[SOLO_PIN] && pad_out[SOLO_PIN] == txa_val));

    // R11: the synchronized view lags the pads by two edges
    p_sync_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (pin_sync == $past(pad_in, 2)));
endmodule

// File: tb/tb_gpio_port_prio.sv
module tb_gpio_port_prio;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       txa_en, txa_val, txb_en, txb_val, cs_en, cs_val;
    logic [7:0] pad_in, pad_out, pad_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_prio dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txa_en(txa_en), .txa_val(txa_val), .txb_en(txb_en), .txb_val(txb_val),
        .cs_en(cs_en), .cs_val(cs_val), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, lat, dir, pin, eo, ee;
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        txa_en = 0; txa_val = 0; txb_en = 0; txb_val = 0; cs_en = 0; cs_val = 0;
        pad_in = 8'h3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset state
        chk("R5 rdata", bus_rdata, 8'h00);
        chk("R5 oe", pad_oe, 8'h00);
        rd(2'd2, r); chk("R5 dir", r, 8'h00);
        rd(2'd0, r); chk("R2 data all inputs", r, 8'h3C);
        wr(2'd2, 8'hFF);
        rd(2'd0, r); chk("R5 latch", r, 8'h00);
        wr(2'd2, 8'h00);

        // R1 R2 R3 R9: sweep every direction mask
        for (int d = 0; d < 256; d++) begin
            dir = 8'(d);
            lat = 8'(d) ^ 8'h5A;
            pin = 8'(d * 37 + 11);
            pad_in = pin;
            wr(2'd2, dir);
            wr(2'd0, lat);
            idle(2);
            rd(2'd0, r); chk("R1/R2 data mux", r, (lat & dir) | (pin & ~dir));
            rd(2'd1, r); chk("R3 input view", r, pin);
            rd(2'd2, r); chk("R12 dir at addr 2", r, dir);
            chk("R9 oe", pad_oe, dir);
            chk("R9 out", pad_out, lat);
        end

        // R4 and R12: writes to the input register and to address 3
        wr(2'd2, 8'hF0); wr(2'd0, 8'hA5);
        wr(2'd1, 8'h0F);
        rd(2'd2, r); chk("R4 dir untouched", r, 8'hF0);
        chk("R4 latch untouched", pad_out, 8'hA5);
        wr(2'd3, 8'h3C);
        rd(2'd2, r); chk("R12 dir after addr3 write", r, 8'hF0);
        chk("R12 latch after addr3 write", pad_out, 8'hA5);
        rd(2'd3, r); chk("R12 addr3 reads 0", r, 8'h00);

        // R13: bus_rdata holds without a read strobe
        rd(2'd2, r);
        idle(3);
        chk("R13 hold", bus_rdata, 8'hF0);

        // R11: synchronizer delay, back-to-back reads from the pin change
        pad_in = 8'h00; idle(3);
        pad_in = 8'hFF;
        rd(2'd1, r); chk("R11 strobe same cycle", r, 8'h00);
        rd(2'd1, r); chk("R11 strobe +1", r, 8'h00);
        rd(2'd1, r); chk("R11 strobe +2", r, 8'hFF);

        // R6 R7 R8 R10: all override combinations, latch written under each
        wr(2'd2, 8'h00);
        for (int c = 0; c < 64; c++) begin
            {txa_en, txa_val, txb_en, txb_val, cs_en, cs_val} = 6'(c);
            lat = 8'(c * 13 + 7);
            dir = (c[0]) ? 8'h00 : 8'hFF;
            wr(2'd2, dir);
            wr(2'd0, lat);
            ee = dir; eo = lat;
            if (txb_en) begin ee[0] = 1'b1; eo[0] = txb_val; end
            else if (cs_en) begin ee[0] = 1'b1; eo[0] = cs_val; end
            if (txa_en) begin ee[1] = 1'b1; eo[1] = txa_val; end
            if (txb_en)              chk("R6 shared pin", {pad_oe[0], pad_out[0]}, {ee[0], eo[0]});
            else if (cs_en)          chk("R7 shared pin", {pad_oe[0], pad_out[0]}, {ee[0], eo[0]});
            if (txa_en)              chk("R8 solo pin", {pad_oe[1], pad_out[1]}, {ee[1], eo[1]});
            chk("R9 pad_oe", pad_oe, ee);
            chk("R9 pad_out", pad_out, eo);
        end
        // release overrides: the last written latch must appear (R10)
        txa_en = 0; txb_en = 0; cs_en = 0;
        wr(2'd2, 8'hFF);
        chk("R10 latch kept", pad_out, 8'(63 * 13 + 7));
        chk("R10 oe", pad_oe, 8'hFF);
        rd(2'd0, r); chk("R10 read latch", r, 8'(63 * 13 + 7));

        // R10: latch written while direction is input, then driven
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hC3);
        chk("R10 not driven", pad_oe, 8'h00);
        wr(2'd2, 8'hFF);
        chk("R10 driven value", pad_out, 8'hC3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule